// File: doc/BRIEF.md
# Dual Word FIFO with Threshold Ready Flags

This block holds the two word-wide queues that sit between a host register port and a serial shifter. The transmit queue is filled by the host and drained by the shifter. The receive queue is filled by the shifter and drained by the host. Each queue reports full and empty. Each also has a ready flag that compares its occupancy with a 3-bit level the host programs. Each also keeps sticky flags for a push into a full queue and a pop from an empty queue.

The host empties both queues with a one-cycle flush command. The flush status bit drops by itself once the flush is done, so software can poll it. A soft-reset input empties both queues for as long as it is held high. Both queues are show-ahead: the word at the head is always on the read data output, and a pop moves to the next one.

Top module: `spi_fifo_pair`

## Requirements
- R1: Words pushed on `host_wpush` come out on `shf_rdata` in push order. The head word is visible with no pop. `shf_rpop` advances to the next word. Each queue holds DEPTH = 8 words.
- R2: Words pushed on `shf_wpush` come out on `host_rdata` in push order, with the same show-ahead behaviour.
- R3: A queue's full flag is 1 exactly when it holds 8 words. Its empty flag is 1 exactly when it holds 0 words.
- R4: A push into a full queue is dropped and sets that queue's sticky overflow flag. The stored words and their order stay unchanged.
- R5: A pop from an empty queue returns data 0 and sets that queue's sticky underflow flag. It does not move the pointers, so the next pushed word is the next one read.
- R6: `rf_ready` is 1 exactly when the receive queue holds more words than `rd_level`.
- R7: `wf_ready` is 1 exactly when the free space in the transmit queue (8 minus occupancy) is greater than `wr_level`.
- R8: A 1 on `flush_req` at a clock edge makes `flush_busy` read 1 for exactly one cycle. At the next edge both queues become empty, all four sticky flags clear, and `flush_busy` returns to 0. Pushes and pops in that cycle are discarded.
- R9: While `soft_rst` is 1, each clock edge empties both queues, clears the sticky flags and `flush_busy`, and discards pushes and pops.
- R10: A push and a pop on the same queue in the same cycle are both judged on the occupancy before the edge. On a partly filled queue both take effect and the count is unchanged. On a full queue the pop is served and the push is dropped as an overflow. On an empty queue the pop underflows and the push is stored.
- R11: After `rst_n` is low at a clock edge, both queues are empty and not full, the sticky flags and `flush_busy` are 0, `rf_ready` is 0 and `wf_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Holds both queues empty while 1 |
| flush_req | input | 1 | One-cycle request to empty both queues |
| flush_busy | output | 1 | Flush status bit, clears itself after one cycle |
| wr_level | input | 3 | Transmit-queue free-space level for `wf_ready` |
| rd_level | input | 3 | Receive-queue occupancy level for `rf_ready` |
| host_wpush | input | 1 | Host push into the transmit queue |
| host_wdata | input | 32 | Word to push into the transmit queue |
| shf_rpop | input | 1 | Shifter pop from the transmit queue |
| shf_rdata | output | 32 | Transmit-queue head word, 0 when empty |
| shf_wpush | input | 1 | Shifter push into the receive queue |
| shf_wdata | input | 32 | Word to push into the receive queue |
| host_rpop | input | 1 | Host pop from the receive queue |
| host_rdata | output | 32 | Receive-queue head word, 0 when empty |
| wf_full | output | 1 | Transmit queue full |
| wf_empty | output | 1 | Transmit queue empty |
| wf_ready | output | 1 | Transmit-queue free space above `wr_level` |
| wf_ovf | output | 1 | Sticky transmit-queue overflow |
| wf_udf | output | 1 | Sticky transmit-queue underflow |
| rf_full | output | 1 | Receive queue full |
| rf_empty | output | 1 | Receive queue empty |
| rf_ready | output | 1 | Receive-queue occupancy above `rd_level` |
| rf_ovf | output | 1 | Sticky receive-queue overflow |
| rf_udf | output | 1 | Sticky receive-queue underflow |

## Verification
The assertions assume the control inputs are synchronous to `clk` and have settled by each rising edge. They also assume `flush_req` and `soft_rst` take part only once `rst_n` is high, and they make no claim during the reset cycles. The stimulus changes every input one time unit after a rising edge and holds it to the next edge. Pushes into full queues, pops from empty ones, and pushes issued during a flush or soft reset are applied on purpose, because each one has a defined result.

// File: rtl/spi_fifo_pkg.sv
// Shared sizes and the per-queue status bundle for the dual word FIFO.
// Assumes: queue depth fits in a 4-bit occupancy count at the defaults.
package spi_fifo_pkg;
    localparam int WORD_W     = 32;
    localparam int FIFO_DEPTH = 8;
    localparam int LEVEL_W    = 3;

    typedef struct packed {
        logic full;
        logic empty;
        logic ready;
        logic ovf;
        logic udf;
    } fifo_status_t;
endpackage

// File: rtl/spi_fifo_flush_ctrl.sv
// Flush and soft-reset sequencing for both queues.
// Does: turns a one-cycle flush request into a status bit that stays up for one
// cycle and produces the queue clear strobe.
// Assumes: flush_req and soft_rst are synchronous to clk.
module spi_fifo_flush_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic flush_req,
    output logic flush_busy,
    output logic fifo_clr
);
    // Flush status bit: latched from the request, dropped after one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) flush_busy <= 1'b0;
        else                    flush_busy <= flush_req;
    end

    // Queue clear: active for soft reset or for the cycle the flush is pending.
    always_comb fifo_clr = soft_rst | flush_busy;

    a_r8_flush_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy && !flush_req |=> !flush_busy);
    a_r9_srst_drops_flush: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !flush_busy);
endmodule

// File: rtl/spi_word_fifo.sv
// Single show-ahead word queue with occupancy count, level-based ready flag and
// sticky error flags.
// Does: holds up to DEPTH words. A push when full and a pop when empty are dropped
// and recorded. A pop when empty reads 0.
// Assumes: clr is synchronous and overrides any push or pop in the same cycle.
module spi_word_fifo #(
    parameter int WIDTH          = spi_fifo_pkg::WORD_W,
    parameter int DEPTH          = spi_fifo_pkg::FIFO_DEPTH,
    parameter int LVL_W          = spi_fifo_pkg::LEVEL_W,
    parameter bit READY_ON_SPACE = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      push,
    input  logic [WIDTH-1:0]          wdata,
    input  logic                      pop,
    output logic [WIDTH-1:0]          rdata,
    input  logic [LVL_W-1:0]          level,
    output spi_fifo_pkg::fifo_status_t status
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             is_full, is_empty, push_ok, pop_ok, ovf_q, udf_q, ready_w;

    // Occupancy decode and acceptance of this cycle's requests.
    always_comb begin
        is_full  = (count == FULL_CNT);
        is_empty = (count == '0);
        push_ok  = push && !is_full && !clr;
        pop_ok   = pop && !is_empty && !clr;
    end

    // Storage write for accepted pushes.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy update, wrapping at the last entry.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Sticky error flags, cleared only by reset, flush or soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
        end else begin
            if (push && is_full)  ovf_q <= 1'b1;
            if (pop && is_empty)  udf_q <= 1'b1;
        end
    end

    // Ready flag variant: free space for a transmit queue, occupancy for receive.
    generate
        if (READY_ON_SPACE) begin : g_space_ready
            always_comb ready_w = (32'(DEPTH) - 32'(count)) > 32'(level);
        end else begin : g_fill_ready
            always_comb ready_w = 32'(count) > 32'(level);
        end
    endgenerate

    // Head word and status outputs.
    always_comb begin
        rdata         = is_empty ? '0 : mem[rd_ptr];
        status.full   = is_full;
        status.empty  = is_empty;
        status.ready  = ready_w;
        status.ovf    = ovf_q;
        status.udf    = udf_q;
    end

    a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    a_r4_push_full_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        push && status.full && !clr |=> status.ovf);
    a_r4_push_full_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop && status.full && !clr |=> status.full);
    a_r5_pop_empty_sets_udf: assert property (@(posedge clk) disable iff (!rst_n)
        pop && status.empty && !clr |=> status.udf);
    a_r5_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status.empty |-> rdata == '0);
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> status.empty && !status.ovf && !status.udf);
endmodule

// File: rtl/spi_fifo_pair.sv
// Transmit/receive word queue pair between a host port and a serial shifter.
// Does: the host fills the transmit queue and the shifter drains it; the shifter
// fills the receive queue and the host drains it. Flush and soft reset empty both.
// Assumes: all inputs are synchronous to clk; rst_n is a synchronous active-low reset.
module spi_fifo_pair #(
    parameter int WIDTH = spi_fifo_pkg::WORD_W,
    parameter int DEPTH = spi_fifo_pkg::FIFO_DEPTH,
    parameter int LVL_W = spi_fifo_pkg::LEVEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             flush_req,
    output logic             flush_busy,
    input  logic [LVL_W-1:0] wr_level,
    input  logic [LVL_W-1:0] rd_level,
    input  logic             host_wpush,
    input  logic [WIDTH-1:0] host_wdata,
    input  logic             shf_rpop,
    output logic [WIDTH-1:0] shf_rdata,
    input  logic             shf_wpush,
    input  logic [WIDTH-1:0] shf_wdata,
    input  logic             host_rpop,
    output logic [WIDTH-1:0] host_rdata,
    output logic             wf_full,
    output logic             wf_empty,
    output logic             wf_ready,
    output logic             wf_ovf,
    output logic             wf_udf,
    output logic             rf_full,
    output logic             rf_empty,
    output logic             rf_ready,
    output logic             rf_ovf,
    output logic             rf_udf
);
    spi_fifo_pkg::fifo_status_t tx_st, rx_st;
    logic fifo_clr;

    spi_fifo_flush_ctrl u_flush (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .flush_req  (flush_req),
        .flush_busy (flush_busy),
        .fifo_clr   (fifo_clr)
    );

    spi_word_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH), .LVL_W(LVL_W), .READY_ON_SPACE(1'b1)) u_tx (
        .clk (clk), .rst_n (rst_n), .clr (fifo_clr),
        .push (host_wpush), .wdata (host_wdata),
        .pop (shf_rpop), .rdata (shf_rdata),
        .level (wr_level), .status (tx_st)
    );

    spi_word_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH), .LVL_W(LVL_W), .READY_ON_SPACE(1'b0)) u_rx (
        .clk (clk), .rst_n (rst_n), .clr (fifo_clr),
        .push (shf_wpush), .wdata (shf_wdata),
        .pop (host_rpop), .rdata (host_rdata),
        .level (rd_level), .status (rx_st)
    );

    // Flatten both status bundles onto the port list.
    always_comb begin
        {wf_full, wf_empty, wf_ready, wf_ovf, wf_udf} = tx_st;
        {rf_full, rf_empty, rf_ready, rf_ovf, rf_udf} = rx_st;
    end

    a_r8_flush_empties_both: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |=> wf_empty && rf_empty && !wf_ovf && !rf_ovf && !wf_udf && !rf_udf);
    a_r9_srst_empties_both: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> wf_empty && rf_empty && !flush_busy);
    a_r3_full_empty_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wf_full && wf_empty) && !(rf_full && rf_empty));
endmodule

// File: tb/test_spi_fifo_pair.sv
module test_spi_fifo_pair;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0, flush_req = 1'b0;
    logic [2:0] wr_level = 3'd0, rd_level = 3'd0;
    logic host_wpush = 1'b0, shf_rpop = 1'b0, shf_wpush = 1'b0, host_rpop = 1'b0;
    logic [31:0] host_wdata = '0, shf_wdata = '0;
    logic [31:0] shf_rdata, host_rdata;
    logic flush_busy, wf_full, wf_empty, wf_ready, wf_ovf, wf_udf;
    logic rf_full, rf_empty, rf_ready, rf_ovf, rf_udf;

    int n_checks = 0;
    int n_fail = 0;
    logic finished = 1'b0;

    // Reference model state
    logic [31:0] wq[$];
    logic [31:0] rq[$];
    logic m_wovf = 0, m_wudf = 0, m_rovf = 0, m_rudf = 0, m_busy = 0;

    always #10 clk = ~clk;

    spi_fifo_pair i_spi_fifo_pair (
        .clk (clk), .rst_n (rst_n), .soft_rst (soft_rst), .flush_req (flush_req),
        .flush_busy (flush_busy), .wr_level (wr_level), .rd_level (rd_level),
        .host_wpush (host_wpush), .host_wdata (host_wdata), .shf_rpop (shf_rpop),
        .shf_rdata (shf_rdata), .shf_wpush (shf_wpush), .shf_wdata (shf_wdata),
        .host_rpop (host_rpop), .host_rdata (host_rdata),
        .wf_full (wf_full), .wf_empty (wf_empty), .wf_ready (wf_ready),
        .wf_ovf (wf_ovf), .wf_udf (wf_udf), .rf_full (rf_full), .rf_empty (rf_empty),
        .rf_ready (rf_ready), .rf_ovf (rf_ovf), .rf_udf (rf_udf)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare every flag against the model.
    task automatic check_flags(input string tag);
        logic [10:0] act, exp;
        act = {flush_busy, wf_full, wf_empty, wf_ready, wf_ovf, wf_udf,
               rf_full, rf_empty, rf_ready, rf_ovf, rf_udf};
        exp = {m_busy, wq.size() == 8, wq.size() == 0, (8 - wq.size()) > int'(wr_level),
               m_wovf, m_wudf, rq.size() == 8, rq.size() == 0, rq.size() > int'(rd_level),
               m_rovf, m_rudf};
        check(act == exp, tag, 32'(act), 32'(exp));
    endtask

    // Driver: apply one cycle of stimulus, update the model, compare popped data.
    task automatic step(input bit wpush, input logic [31:0] wd, input bit wpop,
                        input bit rpush, input logic [31:0] rd, input bit rpop,
                        input bit flush, input bit srst, input string tag);
        int wsz, rsz;
        logic [31:0] exp;
        wsz = wq.size();
        rsz = rq.size();
        host_wpush = wpush; host_wdata = wd; shf_rpop = wpop;
        shf_wpush = rpush; shf_wdata = rd; host_rpop = rpop;
        flush_req = flush; soft_rst = srst;
        // Monitor: head words against the scoreboard before the edge
        if (wpop) begin
            exp = (wsz > 0) ? wq[0] : 32'h0;
            check(shf_rdata === exp, {tag, " tx head"}, shf_rdata, exp);
        end
        if (rpop) begin
            exp = (rsz > 0) ? rq[0] : 32'h0;
            check(host_rdata === exp, {tag, " rx head"}, host_rdata, exp);
        end
        if (srst || m_busy) begin
            wq.delete(); rq.delete();
            m_wovf = 0; m_wudf = 0; m_rovf = 0; m_rudf = 0;
            m_busy = srst ? 1'b0 : flush;
        end else begin
            if (wpop) begin if (wsz > 0) void'(wq.pop_front()); else m_wudf = 1; end
            if (wpush) begin if (wsz < 8) wq.push_back(wd); else m_wovf = 1; end
            if (rpop) begin if (rsz > 0) void'(rq.pop_front()); else m_rudf = 1; end
            if (rpush) begin if (rsz < 8) rq.push_back(rd); else m_rovf = 1; end
            m_busy = flush;
        end
        @(posedge clk);
        #1;
        host_wpush = 0; shf_rpop = 0; shf_wpush = 0; host_rpop = 0;
        flush_req = 0; soft_rst = 0;
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin : watchdog
        #(20 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stimulus
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R11: reset state
        check_flags("R11 reset flags");
        check(shf_rdata == 0 && host_rdata == 0, "R11 reset data", shf_rdata, 0);

        // R1: transmit queue order
        for (int i = 0; i < 5; i++) step(1, 32'hA000 + i, 0, 0, 0, 0, 0, 0, "R1 push");
        check_flags("R1 after pushes");
        for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 0, 0, 0, 0, "R1 pop");
        check_flags("R1 drained");

        // R3 and R4: fill to 8, then a dropped ninth push
        for (int i = 0; i < 8; i++) step(1, 32'hB000 + i, 0, 0, 0, 0, 0, 0, "R3 fill");
        check(wf_full == 1, "R3 full at 8", wf_full, 1);
        step(1, 32'hDEAD, 0, 0, 0, 0, 0, 0, "R4 overflow push");
        check(wf_ovf == 1, "R4 ovf sticky", wf_ovf, 1);
        check_flags("R4 after overflow");
        // R10: full queue, push and pop together
        step(1, 32'hBEEF, 1, 0, 0, 0, 0, 0, "R10 full push+pop");
        check_flags("R10 full push+pop flags");
        for (int i = 0; i < 7; i++) step(0, 0, 1, 0, 0, 0, 0, 0, "R4 order kept");
        check_flags("R3 empty after drain");

        // R5: pop empty reads zero, pointers unmoved
        step(0, 0, 1, 0, 0, 1, 0, 0, "R5 pop empty");
        check(wf_udf == 1 && rf_udf == 1, "R5 udf sticky", {wf_udf, rf_udf}, 2'b11);
        step(1, 32'hC0DE, 0, 0, 0, 0, 0, 0, "R5 push after udf");
        step(0, 0, 1, 0, 0, 0, 0, 0, "R5 next read");
        check_flags("R5 flags");

        // R10: empty queue push+pop, then partly filled push+pop
        step(0, 0, 0, 1, 32'h0E01, 1, 0, 0, "R10 empty push+pop");
        check_flags("R10 empty push+pop flags");
        step(0, 0, 0, 1, 32'h0E02, 0, 0, 0, "R10 fill");
        step(0, 0, 0, 1, 32'h0E03, 1, 0, 0, "R10 mid push+pop");
        check_flags("R10 mid flags");

        // R8: flush with contents and sticky flags present
        step(1, 32'h1, 0, 0, 0, 0, 0, 0, "R8 prep");
        step(0, 0, 0, 0, 0, 0, 1, 0, "R8 flush req");
        check(flush_busy == 1, "R8 busy one cycle", flush_busy, 1);
        check(wf_empty == 0, "R8 not yet cleared", wf_empty, 0);
        step(1, 32'h77, 0, 1, 32'h88, 0, 0, 0, "R8 push during flush");
        check(flush_busy == 0, "R8 busy self clear", flush_busy, 0);
        check_flags("R8 flushed");

        // R2 and R6: receive order and occupancy level
        rd_level = 3'd2;
        step(0, 0, 0, 1, 32'hD000, 0, 0, 0, "R6 rx1");
        step(0, 0, 0, 1, 32'hD001, 0, 0, 0, "R6 rx2");
        check(rf_ready == 0, "R6 two not above 2", rf_ready, 0);
        step(0, 0, 0, 1, 32'hD002, 0, 0, 0, "R6 rx3");
        check(rf_ready == 1, "R6 three above 2", rf_ready, 1);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 1, 0, 0, "R2 pop order");
        check_flags("R2 drained");

        // R7: free-space level
        wr_level = 3'd5;
        step(1, 32'hE000, 0, 0, 0, 0, 0, 0, "R7 tx1");
        step(1, 32'hE001, 0, 0, 0, 0, 0, 0, "R7 tx2");
        check(wf_ready == 1, "R7 space 6 above 5", wf_ready, 1);
        step(1, 32'hE002, 0, 0, 0, 0, 0, 0, "R7 tx3");
        check(wf_ready == 0, "R7 space 5 not above 5", wf_ready, 0);
        wr_level = 3'd7;
        check_flags("R7 level 7");

        // R9: soft reset held with pushes applied
        step(0, 0, 1, 0, 0, 1, 0, 0, "R9 prep udf");
        step(0, 0, 0, 0, 0, 0, 1, 0, "R9 flush before srst");
        step(1, 32'hF0, 0, 1, 32'hF1, 0, 0, 1, "R9 srst 1");
        step(1, 32'hF2, 0, 1, 32'hF3, 0, 0, 1, "R9 srst 2");
        check_flags("R9 after soft reset");
        idle("R9 idle");
        check_flags("R9 still empty");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule